// File: doc/BRIEF.md
# Condition-Code Masked Write-Back Unit

This unit sits at the end of a shader execution lane. It merges a four-lane result vector into a destination register value. It also keeps a four-lane condition-code register that records the sign class of the lanes it writes.

Each write is gated per lane by two things:
- a static component mask;
- a run-time test. The condition-code vector is first permuted by a per-lane source selector, and each permuted code is then compared against one selected rule.

The merged destination is presented combinationally. The condition-code register changes only on a clock edge where the write strobe is high. A discard indication is raised whenever any permuted lane passes the selected rule, so that a fragment can be killed on a condition-code test.

The result lanes carry IEEE single-precision bit patterns. A code is regenerated only for lanes that are actually written, and only when regeneration is requested. NaN gets its own unordered code.

Top module: `ccw_top`

## Requirements
- R1: After asynchronous reset (rst_n low), every condition-code lane holds EQ. A synchronous `cc_init` also returns every lane to EQ on the next clock edge. Code encodings are EQ=2'b00, LT=2'b01, GT=2'b10 and UN=2'b11. Lane i (x=0, y=1, z=2, w=3) sits at `cc_o[2i+1:2i]`.
- R2: A written lane's new code is derived from its 32-bit result as follows:
  - UN when the exponent bits [30:23] are all ones and the mantissa bits [22:0] are non-zero;
  - EQ for +0.0 and for -0.0;
  - LT for any other value with sign bit 31 set, including -infinity;
  - GT otherwise, including +infinity and positive denormals.
- R3: The code tested for lane i is the stored code of lane `cc_swz_i[2i+1:2i]`. 8'hE4 is the identity order.
- R4: Test encodings on `cc_test_i` are EQ=2, NE=3, LT=4, GE=5, LE=6 and GT=7. Each passes on the matching code(s). NE passes on any code other than EQ. A UN code passes NE and fails every other comparison.
- R5: Test code 0 (always) passes every lane, and it is the value to use when no test is given. Test code 1 (never) passes no lane.
- R6: Lane i of `dest_o` equals lane i of `result_i` exactly when `wmask_i[i]` is set and the lane's test passes. Otherwise it equals lane i of `dest_i`. Lane i occupies bits [32i+31:32i].
- R7: On a clock edge with `wr_stb` high and `cc_upd_i` high, each written lane takes its R2 code. Unwritten lanes keep their code. With `cc_upd_i` low or `wr_stb` low, no code changes.
- R8: `cc_init` takes priority over a simultaneous write.
- R9: `kill_o` is high exactly when at least one permuted lane passes the selected test, whatever the write mask.
- R10: Start from reset and use the values (-2, 0, 2, NaN). A full always-pass write gives (LT,EQ,GT,UN). Writing the permuted values (0,2,NaN,-2) with mask xyz then gives (EQ,GT,UN,UN). Writing (2,0,NaN,-2) under NE with identity order then leaves x unwritten and gives (EQ,EQ,UN,LT).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cc_init | input | 1 | Synchronous return of all codes to EQ |
| wr_stb | input | 1 | Commit strobe for the condition-code update |
| result_i | input | 128 | Four single-precision result lanes |
| dest_i | input | 128 | Current destination register value |
| wmask_i | input | 4 | Static component write mask, bit 0 = x |
| cc_swz_i | input | 8 | Per-lane condition-code source selector |
| cc_test_i | input | 3 | Selected condition test |
| cc_upd_i | input | 1 | Regenerate codes of written lanes |
| dest_o | output | 128 | Merged destination value |
| cc_o | output | 8 | Current condition-code vector |
| kill_o | output | 1 | Some permuted lane passes the test |

## Verification
The hardest cases to reach are the ones that need a particular mixed condition-code state, such as an UN lane beside LT and GT lanes under a non-identity source order. Such states can only be built through earlier writes. The vector table therefore runs as one continuous program: each row depends on the codes left by the rows before it. This drives UN into lanes one by one and then tests them under NE, EQ and the ordered rules. Separate directed steps then cover the case where init and a write land on the same edge, and the case where a strobe arrives with update disabled.

// File: rtl/ccw_pkg.sv
package ccw_pkg;
    localparam int NLANE   = 4;
    localparam int FW      = 32;
    localparam int EXP_W   = 8;
    localparam int MAN_W   = 23;
    localparam int SEL_W   = $clog2(NLANE);

    typedef enum logic [1:0] {
        CC_EQ = 2'b00,
        CC_LT = 2'b01,
        CC_GT = 2'b10,
        CC_UN = 2'b11
    } cc_e;

    typedef enum logic [2:0] {
        T_TR = 3'd0,
        T_FL = 3'd1,
        T_EQ = 3'd2,
        T_NE = 3'd3,
        T_LT = 3'd4,
        T_GE = 3'd5,
        T_LE = 3'd6,
        T_GT = 3'd7
    } test_e;
endpackage

// File: rtl/ccw_classify.sv
module ccw_classify
    import ccw_pkg::*;
(
    input  logic [FW-1:0] value,
    output cc_e           code
);
    logic              sgn;
    logic [EXP_W-1:0]  expo;
    logic [MAN_W-1:0]  man;

    assign sgn  = value[FW-1];
    assign expo = value[FW-2 -: EXP_W];
    assign man  = value[MAN_W-1:0];

    // R2: NaN first, then signed zero, then sign decides.
    always_comb begin
        if (&expo && |man)
            code = CC_UN;
        else if (expo == '0 && man == '0)
            code = CC_EQ;
        else if (sgn)
            code = CC_LT;
        else
            code = CC_GT;
    end
endmodule

// File: rtl/ccw_lane_test.sv
module ccw_lane_test
    import ccw_pkg::*;
(
    input  cc_e   code,
    input  test_e rule,
    output logic  pass
);
    always_comb begin
        unique case (rule)
            T_TR: pass = 1'b1;
            T_FL: pass = 1'b0;
            T_EQ: pass = (code == CC_EQ);
            T_NE: pass = (code != CC_EQ);
            T_LT: pass = (code == CC_LT);
            T_GE: pass = (code == CC_GT) || (code == CC_EQ);
            T_LE: pass = (code == CC_LT) || (code == CC_EQ);
            T_GT: pass = (code == CC_GT);
            default: pass = 1'b0;
        endcase
    end

    // R4: an unordered code passes only the not-equal rule (and always).
    always_comb begin
        if (code == CC_UN && rule != T_NE && rule != T_TR)
            a_r4_un_fails_ordered: assert (pass !== 1'b1);
    end
endmodule

// File: rtl/ccw_top.sv
module ccw_top
    import ccw_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cc_init,
    input  logic                wr_stb,
    input  logic [NLANE*FW-1:0] result_i,
    input  logic [NLANE*FW-1:0] dest_i,
    input  logic [NLANE-1:0]    wmask_i,
    input  logic [NLANE*SEL_W-1:0] cc_swz_i,
    input  logic [2:0]          cc_test_i,
    input  logic                cc_upd_i,
    output logic [NLANE*FW-1:0] dest_o,
    output logic [NLANE*2-1:0]  cc_o,
    output logic                kill_o
);
    cc_e              cc_q   [NLANE];
    cc_e              tested [NLANE];
    cc_e              fresh  [NLANE];
    logic [NLANE-1:0] pass;
    logic [NLANE-1:0] lane_en;
    test_e            rule;

    assign rule = test_e'(cc_test_i);

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        // R3: permute before testing
        assign tested[i] = cc_q[cc_swz_i[i*SEL_W +: SEL_W]];

        ccw_lane_test u_test (
            .code (tested[i]),
            .rule (rule),
            .pass (pass[i])
        );

        ccw_classify u_cls (
            .value (result_i[i*FW +: FW]),
            .code  (fresh[i])
        );

        assign lane_en[i] = wmask_i[i] & pass[i];
        assign dest_o[i*FW +: FW] = lane_en[i] ? result_i[i*FW +: FW]
                                               : dest_i[i*FW +: FW];
        assign cc_o[2*i +: 2] = cc_q[i];

        a_r6_masked_lane_holds: assert property (@(posedge clk) disable iff (!rst_n)
            !wmask_i[i] |-> dest_o[i*FW +: FW] == dest_i[i*FW +: FW]);

        a_r7_unwritten_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stb && !cc_init && !(wmask_i[i] && pass[i])) |=> cc_o[2*i +: 2] == $past(cc_o[2*i +: 2]));
    end

    assign kill_o = |pass;

    // R1, R7, R8: condition-code register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NLANE; i++) cc_q[i] <= CC_EQ;
        end else if (cc_init) begin
            for (int i = 0; i < NLANE; i++) cc_q[i] <= CC_EQ;
        end else if (wr_stb && cc_upd_i) begin
            for (int i = 0; i < NLANE; i++)
                if (lane_en[i]) cc_q[i] <= fresh[i];
        end
    end

    a_r1_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cc_init |=> cc_o == '0);

    a_r5_never_no_kill: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_test_i == 3'd1) |-> !kill_o);

    a_r7_no_update_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!cc_init && !(wr_stb && cc_upd_i)) |=> $stable(cc_o));
endmodule

// File: tb/ccw_top_tb_top.sv
module ccw_top_tb_top;
    localparam logic [127:0] DEST = 128'hD0D0D0D3_D0D0D0D2_D0D0D0D1_D0D0D0D0;

    typedef struct packed {
        logic [127:0] res;
        logic [3:0]   wm;
        logic [7:0]   swz;
        logic [2:0]   tst;
        logic         upd;
        logic [3:0]   en;
        logic [7:0]   cc;
        logic         kill;
    } vec_t;

    // Rows run as one program; each depends on codes left by the previous row.
    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        // R10 step 1: full always-pass write
        '{128'h7FC00000_40000000_00000000_C0000000, 4'hF, 8'hE4, 3'd0, 1'b1, 4'hF, 8'hE1, 1'b1},
        // R10 step 2: mask xyz
        '{128'hC0000000_7FC00000_40000000_00000000, 4'h7, 8'hE4, 3'd0, 1'b1, 4'h7, 8'hF8, 1'b1},
        // R10 step 3: NE test, x blocked
        '{128'hC0000000_7FC00000_00000000_40000000, 4'hF, 8'hE4, 3'd3, 1'b1, 4'hE, 8'h70, 1'b1},
        // R3: all lanes read w (LT) under LT, no update
        '{128'h3F800000_3F800000_3F800000_3F800000, 4'hF, 8'hFF, 3'd4, 1'b0, 4'hF, 8'h70, 1'b1},
        // R2/R4: GE on (EQ,EQ,UN,LT); -0.0 -> EQ, +inf -> GT
        '{128'h3F800000_3F800000_7F800000_80000000, 4'hF, 8'hE4, 3'd5, 1'b1, 4'h3, 8'h78, 1'b1},
        // R5: never
        '{128'hBF800000_BF800000_BF800000_BF800000, 4'hF, 8'hE4, 3'd1, 1'b1, 4'h0, 8'h78, 1'b0},
        // R4/R9: LE, mask blocks x, w NaN -> UN
        '{128'h7FC00000_3F800000_3F800000_3F800000, 4'hE, 8'hE4, 3'd6, 1'b1, 4'h8, 8'hF8, 1'b1},
        // R4: GT only on y; -1 -> LT
        '{128'h3F800000_3F800000_BF800000_3F800000, 4'hF, 8'hE4, 3'd7, 1'b1, 4'h2, 8'hF4, 1'b1},
        // R2: small-mantissa NaN under EQ on x
        '{128'h3F800000_3F800000_3F800000_7F800001, 4'hF, 8'hE4, 3'd2, 1'b1, 4'h1, 8'hF7, 1'b1},
        // R9: EQ with no EQ code left -> no kill
        '{128'h00000000_00000000_00000000_00000000, 4'hF, 8'hE4, 3'd2, 1'b1, 4'h0, 8'hF7, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cc_init = 1'b0;
    logic         wr_stb = 1'b0;
    logic [127:0] result_i = '0;
    logic [127:0] dest_i = DEST;
    logic [3:0]   wmask_i = '0;
    logic [7:0]   cc_swz_i = 8'hE4;
    logic [2:0]   cc_test_i = '0;
    logic         cc_upd_i = 1'b0;
    logic [127:0] dest_o;
    logic [7:0]   cc_o;
    logic         kill_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    ccw_top dut_i (
        .clk(clk), .rst_n(rst_n), .cc_init(cc_init), .wr_stb(wr_stb),
        .result_i(result_i), .dest_i(dest_i), .wmask_i(wmask_i),
        .cc_swz_i(cc_swz_i), .cc_test_i(cc_test_i), .cc_upd_i(cc_upd_i),
        .dest_o(dest_o), .cc_o(cc_o), .kill_o(kill_o)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] merge(input logic [127:0] r, input logic [127:0] d, input logic [3:0] en);
        logic [127:0] m;
        for (int i = 0; i < 4; i++) m[i*32 +: 32] = en[i] ? r[i*32 +: 32] : d[i*32 +: 32];
        return m;
    endfunction

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [127:0] exp_d;
        repeat (2) @(negedge clk);
        check(cc_o == 8'h00, "R1 reset", {120'd0, cc_o}, 128'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            result_i  = TBL[k].res;
            wmask_i   = TBL[k].wm;
            cc_swz_i  = TBL[k].swz;
            cc_test_i = TBL[k].tst;
            cc_upd_i  = TBL[k].upd;
            #1;
            exp_d = merge(TBL[k].res, DEST, TBL[k].en);
            check(dest_o == exp_d, "R6 merge", dest_o, exp_d);
            check(kill_o == TBL[k].kill, "R9 kill", {127'd0, kill_o}, {127'd0, TBL[k].kill});
            wr_stb = 1'b1;
            @(negedge clk);
            wr_stb = 1'b0;
            check(cc_o == TBL[k].cc, "R7 R10 codes", {120'd0, cc_o}, {120'd0, TBL[k].cc});
        end

        // R7: strobe without update leaves codes (currently F7)
        result_i = '0; wmask_i = 4'hF; cc_test_i = 3'd0; cc_upd_i = 1'b0;
        wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        check(cc_o == 8'hF7, "R7 no update", {120'd0, cc_o}, 128'hF7);

        // R7: update requested but no strobe
        cc_upd_i = 1'b1;
        @(negedge clk);
        check(cc_o == 8'hF7, "R7 no strobe", {120'd0, cc_o}, 128'hF7);

        // R8: init together with a write that would give GT everywhere
        result_i = {4{32'h3F800000}};
        cc_init = 1'b1; wr_stb = 1'b1;
        @(negedge clk);
        cc_init = 1'b0; wr_stb = 1'b0;
        check(cc_o == 8'h00, "R8 init priority", {120'd0, cc_o}, 128'h0);

        // R4/R9: LT test on all-EQ codes passes nothing
        cc_test_i = 3'd4;
        #1;
        check(kill_o == 1'b0, "R4 LT on EQ", {127'd0, kill_o}, 128'h0);
        check(dest_o == DEST, "R4 LT blocks", dest_o, DEST);

        // R1: init after a write
        cc_test_i = 3'd0; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        check(cc_o == 8'hAA, "R2 positive GT", {120'd0, cc_o}, 128'hAA);
        cc_init = 1'b1;
        @(negedge clk);
        cc_init = 1'b0;
        check(cc_o == 8'h00, "R1 init", {120'd0, cc_o}, 128'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule